// File: doc/BRIEF.md
# Chopped Third-Order Sinc Decimator

This block turns the one-bit output of a sigma-delta modulator into signed result words. Each accepted bit counts as +1 or -1 and feeds a cascade of three accumulators. Once every programmable number of accepted bits, a three-stage difference network turns the accumulators into one sinc3-filtered word. The decimation ratio sets the output word rate and the filter bandwidth.

The block expects the analog front end to swap its input polarity on alternate words. It drives a chop-phase output that changes once per word, so an external multiplexer can follow it. A word taken while the inputs are swapped is negated. Each corrected word is then added to the corrected word before it and the sum is halved, so any fixed offset at the modulator cancels. The average is scaled down to a signed 24-bit result and presented with a one-cycle strobe.

After a reset, or after the ratio changes, the strobe is held off until the filter history and the averaging pair contain only samples taken at the current ratio.

Top module: `chop_sinc3_decim`

## Requirements
- R1: A bit is taken only in a cycle where `mod_en` is high. A 1 counts as +1 and a 0 counts as -1. While `mod_en` stays low, no strobe occurs and `result` does not change.
- R2: With ratio N held, a word is formed on the clock edge that accepts the N-th counted bit. `result_valid` is high for exactly the one cycle after that edge.
- R3: Let d_k be the triple running sum of the ±1 samples taken at word k. The filter word is then d_k - 3·d_(k-1) + 3·d_(k-2) - d_(k-3). All earlier d values count as zero after a reset.
- R4: `chop_phase` is 0 after a reset and toggles on every word. A word formed while `chop_phase` is 1 is negated before averaging.
- R5: With ACC_W = 3·RATIO_LOG2+1 (25 by default), `result` is floor((s_k + s_(k-1)) / 2^(1+ACC_W-24)), where s is the corrected word. This divides by 4 by default. `result` holds its value between strobes.
- R6: A constant input with no external swapping gives a `result` of 0 once the block has settled.
- R7: After a reset, the first four words raise no strobe and the fifth word does. With ratio N, this is 5·N accepted bits after reset release.
- R8: In a cycle where `dec_ratio` differs from its value in the previous cycle, no word is formed. In that cycle the bit count and the settle count restart and `chop_phase` returns to 0. The first strobe follows 1+5·N edges later, counting that edge.
- R9: A `dec_ratio` of 0 or 1 acts as a ratio of 2.
- R10: While reset is held, `result` is 0, `result_valid` is 0 and `chop_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Marks a cycle that carries a modulator bit |
| mod_bit | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| dec_ratio | input | RATIO_LOG2 | Decimation ratio, in accepted bits per word |
| chop_phase | output | 1 | Current chop phase; 1 = front end inputs swapped |
| result | output | OUT_W | Signed averaged result |
| result_valid | output | 1 | One-cycle strobe for a new `result` |

## Verification
A fault in the accumulators or the difference history shows at the ports as a wrong `result` on the next strobe. It persists for at least three words, because the difference network remembers three words. A wrong bit counter shows as a strobe on the wrong edge. A wrong chop register shows as a wrong `chop_phase` level in the very next cycle. A settle counter that restarts badly shows as a missing or early strobe after a reset or a ratio change. The bench compares the strobe and the phase on every cycle. It compares the result on every strobe, so each of these faults is reported within one word period of taking effect.

// File: rtl/chop_sinc3_pkg.sv
// Shared types and width helpers for the chopped sinc3 decimator.
package chop_sinc3_pkg;

    // Polarity of the analog front end during the word being collected.
    typedef enum logic {
        PH_DIRECT  = 1'b0,
        PH_SWAPPED = 1'b1
    } chop_ph_e;

    // Cascade width that holds ratio^3 with a sign bit, wraparound-safe.
    function automatic int acc_width(input int ratio_log2);
        return 3 * ratio_log2 + 1;
    endfunction

endpackage

// File: rtl/sinc3_integrator.sv
// Three cascaded accumulators running at the modulator rate.
// Assumes: two's-complement wraparound is acceptable, because the
// difference stage cancels it. integ_next is the third-stage value that
// includes the bit of the current cycle.
module sinc3_integrator #(
    parameter int ACC_W = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] integ_next
);
    localparam int STAGES = 3;

    logic signed [ACC_W-1:0] acc_q [STAGES];
    logic signed [ACC_W-1:0] acc_d [STAGES];
    logic signed [ACC_W-1:0] step;

    // Map the bit onto +1 or -1.
    assign step = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    // Next-state of the cascade, each stage fed by the updated one before it.
    always_comb begin
        acc_d[0] = acc_q[0] + step;
        for (int s = 1; s < STAGES; s++) begin
            acc_d[s] = acc_q[s] + acc_d[s-1];
        end
    end

    // Accumulator registers advance only on accepted bits.
    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) begin
                acc_q[s] <= '0;
            end else if (sample_en) begin
                acc_q[s] <= acc_d[s];
            end
        end
    end

    assign integ_next = acc_d[STAGES-1];

    // R1: an accepted bit moves the first stage by exactly one step.
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sample_en)) |->
            ((acc_q[0] == $past(acc_q[0]) + ACC_W'(1)) ||
             (acc_q[0] == $past(acc_q[0]) - ACC_W'(1))));

    // R1: without an accepted bit the cascade stays frozen.
    a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample_en)) |-> $stable(acc_q[STAGES-1]));

endmodule

// File: rtl/sinc3_decimator.sv
// Bit counter and three-stage difference network at the word rate.
// Assumes: ratio values below 2 are treated as 2. A change of ratio
// restarts the count, and no word is formed in that cycle.
module sinc3_decimator #(
    parameter int RATIO_W = 8,
    parameter int ACC_W   = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [RATIO_W-1:0]      ratio,
    input  logic signed [ACC_W-1:0] integ,
    output logic                    word_stb,
    output logic                    restart,
    output logic signed [ACC_W-1:0] word
);
    localparam int DIFFS = 3;
    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

    logic [RATIO_W-1:0]      ratio_q;
    logic [RATIO_W-1:0]      ratio_eff;
    logic [RATIO_W-1:0]      cnt_q;
    logic signed [ACC_W-1:0] dly_q [DIFFS];
    logic signed [ACC_W-1:0] st    [DIFFS+1];

    // Clamp the programmed ratio to the smallest usable value.
    assign ratio_eff = (ratio_q < MIN_RATIO) ? MIN_RATIO : ratio_q;
    assign restart   = (ratio != ratio_q);
    assign word_stb  = sample_en && !restart && (cnt_q == ratio_eff - 1'b1);

    // Remember the ratio of the previous cycle, loaded during reset too.
    always_ff @(posedge clk) begin
        ratio_q <= ratio;
    end

    // Count accepted bits within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (sample_en) begin
            cnt_q <= word_stb ? '0 : cnt_q + 1'b1;
        end
    end

    // Difference chain against the values stored at the previous word.
    always_comb begin
        st[0] = integ;
        for (int s = 0; s < DIFFS; s++) begin
            st[s+1] = st[s] - dly_q[s];
        end
    end

    // Store each stage's input for the next word.
    always_ff @(posedge clk) begin
        for (int s = 0; s < DIFFS; s++) begin
            if (!rst_n) begin
                dly_q[s] <= '0;
            end else if (word_stb) begin
                dly_q[s] <= st[s];
            end
        end
    end

    assign word = st[DIFFS];

    // R2: the count never reaches the effective ratio.
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_eff);

    // R2: a word always leaves the counter at zero.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (cnt_q == '0));

    // R9: with the clamp, two words are never back to back.
    a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

endmodule

// File: rtl/chop_averager.sv
// Chop sign correction, pairwise averaging, settle gating and scaling.
// Assumes: word_stb and restart never occur together. The first
// SETTLE_WORDS words after a restart are used only as history.
module chop_averager
    import chop_sinc3_pkg::*;
#(
    parameter int ACC_W        = 25,
    parameter int OUT_W        = 24,
    parameter int SETTLE_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_stb,
    input  logic                    restart,
    input  logic signed [ACC_W-1:0] word,
    output logic                    chop_phase,
    output logic signed [OUT_W-1:0] result,
    output logic                    result_valid
);
    localparam int SET_W = $clog2(SETTLE_WORDS + 1);
    localparam logic [SET_W-1:0] SETTLED = SET_W'(SETTLE_WORDS);

    chop_ph_e                phase_q;
    logic signed [ACC_W-1:0] prev_q;
    logic signed [ACC_W-1:0] fixed;
    logic signed [ACC_W:0]   pair_sum;
    logic signed [ACC_W-1:0] half;
    logic signed [OUT_W-1:0] scaled;
    logic signed [OUT_W-1:0] result_q;
    logic [SET_W-1:0]        settle_q;
    logic                    settled;
    logic                    valid_q;

    // Undo the front-end swap on odd words.
    assign fixed    = (phase_q == PH_SWAPPED) ? -word : word;
    // Sum with the predecessor at full width, then halve.
    assign pair_sum = {fixed[ACC_W-1], fixed} + {prev_q[ACC_W-1], prev_q};
    assign half     = pair_sum[ACC_W:1];
    assign settled  = (settle_q == SETTLED);

    // Keep the top OUT_W bits, or sign-extend a narrow cascade.
    generate
        if (ACC_W > OUT_W) begin : g_trunc
            assign scaled = half[ACC_W-1 -: OUT_W];
        end else begin : g_extend
            assign scaled = OUT_W'(half);
        end
    endgenerate

    // Phase, history, settle count and the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_DIRECT;
            prev_q   <= '0;
            settle_q <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (restart) begin
                settle_q <= '0;
                phase_q  <= PH_DIRECT;
            end else if (word_stb) begin
                prev_q  <= fixed;
                phase_q <= (phase_q == PH_DIRECT) ? PH_SWAPPED : PH_DIRECT;
                valid_q <= settled;
                if (settled) begin
                    result_q <= scaled;
                end else begin
                    settle_q <= settle_q + 1'b1;
                end
            end
        end
    end

    assign chop_phase   = phase_q;
    assign result       = result_q;
    assign result_valid = valid_q;

    // R4: every word flips the chop phase.
    a_r4_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (chop_phase != $past(chop_phase)));

    // R5: the result only moves together with a strobe.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !result_valid) |-> $stable(result));

    // R2: the strobe lasts a single cycle.
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8: a restart is never followed by a strobe.
    a_r8_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !result_valid);

endmodule

// File: rtl/chop_sinc3_decim.sv
// Top level: sinc3 decimation of a modulator bitstream with chop
// correction and offset-cancelling pairwise averaging.
// Assumes: the front end swaps its input polarity while chop_phase is 1.
module chop_sinc3_decim
    import chop_sinc3_pkg::*;
#(
    parameter int RATIO_LOG2 = 8,
    parameter int OUT_W      = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_en,
    input  logic                    mod_bit,
    input  logic [RATIO_LOG2-1:0]   dec_ratio,
    output logic                    chop_phase,
    output logic signed [OUT_W-1:0] result,
    output logic                    result_valid
);
    localparam int ACC_W        = acc_width(RATIO_LOG2);
    localparam int SETTLE_WORDS = 4;

    logic signed [ACC_W-1:0] integ;
    logic signed [ACC_W-1:0] word;
    logic                    word_stb;
    logic                    restart;

    sinc3_integrator #(.ACC_W(ACC_W)) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (mod_en),
        .bit_in     (mod_bit),
        .integ_next (integ)
    );

    sinc3_decimator #(.RATIO_W(RATIO_LOG2), .ACC_W(ACC_W)) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (mod_en),
        .ratio     (dec_ratio),
        .integ     (integ),
        .word_stb  (word_stb),
        .restart   (restart),
        .word      (word)
    );

    chop_averager #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SETTLE_WORDS(SETTLE_WORDS)) u_avg (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_stb     (word_stb),
        .restart      (restart),
        .word         (word),
        .chop_phase   (chop_phase),
        .result       (result),
        .result_valid (result_valid)
    );

endmodule

// File: tb/tb_chop_sinc3_decim.sv
`timescale 1ns/1ps
module tb_chop_sinc3_decim;
    localparam int  RATIO_LOG2 = 8;
    localparam int  OUT_W      = 24;
    localparam int  ACC_W      = 3 * RATIO_LOG2 + 1;
    localparam int  SHR        = 1 + ACC_W - OUT_W;
    localparam real HALF_NS    = 2.5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    mod_en = 1'b0;
    logic                    mod_bit = 1'b0;
    logic [RATIO_LOG2-1:0]   dec_ratio = 8'd16;
    logic                    chop_phase;
    logic signed [OUT_W-1:0] result;
    logic                    result_valid;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #(HALF_NS) clk = ~clk;

    chop_sinc3_decim #(.RATIO_LOG2(RATIO_LOG2), .OUT_W(OUT_W)) dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
        .dec_ratio(dec_ratio), .chop_phase(chop_phase),
        .result(result), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    longint m_i1, m_i2, m_i3, m_prev, m_result;
    longint hist[$];
    int     m_cnt, m_words, m_rprev;
    bit     m_phase, m_valid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_i1 = 0; m_i2 = 0; m_i3 = 0; m_prev = 0; m_result = 0;
            hist = '{0, 0, 0};
            m_cnt = 0; m_words = 0; m_phase = 0; m_valid = 0;
            m_rprev = dec_ratio;
        end else begin
            bit     rs;
            int     eff;
            longint c, s;
            m_valid = 0;
            rs  = (dec_ratio != m_rprev);
            eff = (m_rprev < 2) ? 2 : m_rprev;
            if (mod_en) begin
                m_i1 += mod_bit ? 1 : -1;
                m_i2 += m_i1;
                m_i3 += m_i2;
            end
            if (rs) begin
                m_cnt = 0; m_words = 0; m_phase = 0;
            end else if (mod_en) begin
                m_cnt++;
                if (m_cnt == eff) begin
                    m_cnt = 0;
                    c = m_i3 - 3 * hist[0] + 3 * hist[1] - hist[2];
                    hist.push_front(m_i3);
                    void'(hist.pop_back());
                    s = m_phase ? -c : c;
                    if (m_words >= 4) begin
                        m_valid  = 1;
                        m_result = (s + m_prev) >>> SHR;
                    end
                    m_prev = s;
                    m_words++;
                    m_phase = ~m_phase;
                end
            end
            m_rprev = dec_ratio;
        end
    end

    // Cycle compare, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(result_valid == m_valid, "R2 R7 strobe", result_valid, m_valid);
            chk(chop_phase == m_phase, "R4 phase", chop_phase, m_phase);
            if (m_valid)
                chk($signed(result) == m_result, "R3 R5 result", $signed(result), m_result);
        end
    end

    // mode 0: random density, swapped with chop_phase; mode 1: constant ones.
    task automatic drive_one(input int mode, input int dens, input int en_pct);
        bit b;
        b = (($urandom % 100) < dens);
        if (mode == 0) b ^= chop_phase;
        if (mode == 1) b = 1'b1;
        mod_bit = b;
        mod_en  = (($urandom % 100) < en_pct);
    endtask

    task automatic run(input int n, input int mode, input int dens, input int en_pct, output int vc);
        vc = 0;
        for (int i = 0; i < n; i++) begin
            drive_one(mode, dens, en_pct);
            @(negedge clk);
            if (result_valid) vc++;
        end
    endtask

    task automatic edges_to_valid(input int mode, input int dens, output int edges, output bit ph0);
        edges = 0;
        ph0 = 1'b0;
        do begin
            drive_one(mode, dens, 100);
            @(negedge clk);
            edges++;
            if (edges == 1) ph0 = (chop_phase == 1'b0);
        end while (!result_valid && edges < 5000);
    endtask

    initial begin
        int vc, e;
        bit p0;
        logic signed [OUT_W-1:0] held;
        repeat (4) @(negedge clk);
        // R10 reset state.
        chk(result == '0, "R10 result", result, 0);
        chk(result_valid == 1'b0, "R10 valid", result_valid, 0);
        chk(chop_phase == 1'b0, "R10 phase", chop_phase, 0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        // R7: first strobe on the fifth word after reset.
        edges_to_valid(0, 70, e, p0);
        chk(e == 5 * 16, "R7 edges to first strobe", e, 5 * 16);
        run(320, 0, 70, 100, vc);
        run(400, 0, 20, 100, vc);
        // R1: no accepted bits, no strobe, result held.
        held = result;
        run(200, 0, 50, 0, vc);
        chk(vc == 0, "R1 strobes while idle", vc, 0);
        chk(result == held, "R1 result held", result, held);
        run(800, 0, 60, 50, vc);
        // R8: ratio change restarts everything.
        dec_ratio = 8'd32;
        edges_to_valid(0, 35, e, p0);
        chk(p0, "R8 phase cleared", !p0, 0);
        chk(e == 1 + 5 * 32, "R8 edges to first strobe", e, 1 + 5 * 32);
        run(400, 0, 90, 100, vc);
        // R9: ratio 1 behaves as 2.
        dec_ratio = 8'd1;
        run(20, 0, 50, 100, vc);
        run(40, 0, 50, 100, vc);
        chk(vc == 20, "R9 strobes in 40 cycles", vc, 20);
        dec_ratio = 8'd0;
        run(20, 0, 50, 100, vc);
        run(40, 0, 50, 100, vc);
        chk(vc == 20, "R9 ratio 0 strobes", vc, 20);
        // R2: ratio 5 gives one word per five bits.
        dec_ratio = 8'd5;
        run(40, 0, 40, 100, vc);
        run(100, 0, 40, 100, vc);
        chk(vc == 20, "R2 strobes in 100 cycles", vc, 20);
        // R6: constant input, no swap, offset cancels.
        dec_ratio = 8'd16;
        run(200, 1, 0, 100, vc);
        chk(result == '0, "R6 constant input", result, 0);
        // Largest ratio, random chopped input.
        dec_ratio = 8'd255;
        run(255 * 8, 0, 80, 100, vc);
        chk(vc == 3, "R2 strobes at max ratio", vc, 3);
        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 2 * HALF_NS);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule